// File: doc/BRIEF.md
# Subwoofer Bass-Management Mixer

This block forms the low-frequency output channel of a six-channel audio datapath. Each frame, a single valid strobe presents one signed sample for each of six fixed channels: left front, right front, left surround, right surround, centre and subwoofer. From these the block builds two candidate subwoofer signals. The first is a bass-management sum, in which the subwoofer sample is raised by 10 dB and the five main channels are added to it. The second is the mean of a left and a right downmix, built only from the main channels that a mask enables.

A select input picks one candidate, and a signed volume coefficient then scales the result. The output drives later filter stages. Every sum and product is signed fixed point and saturates to the sample width. Mode and mask are taken at the first pipeline edge and the volume at the second, so a result appears two cycles after its input strobe.

Top module: `sub_bass_mixer`

## Requirements
- R1: While reset is held and directly after it, `out_vld` is 0 and `out_smp` is 0.
- R2: `out_vld` goes high exactly two clock edges after the edge that captures `in_vld` high, once for each input sample. `out_smp` keeps its value on edges that bring no new result.
- R3: With `src_sel` = 0 the source value is floor((floor(sub·26527108 / 2^23) + lf + rf + ls + rs + c) / 8), saturated to 28 bits. The constant 26527108 is +10 dB (about 3.1623) in a format with 23 fractional bits.
- R4: With `src_sel` = 1 the source value is floor((L + R) / 2), saturated to 28 bits. L = lf + ls + floor(c/2) and R = rf + rs + floor(c/2), counting only the channels that the mask enables.
- R5: `mix_mask` bit 0 enables left front, bit 1 right front, bit 2 left surround, bit 3 right surround and bit 4 centre. A channel whose bit is 0 has no effect. The subwoofer sample never affects the downmix result.
- R6: With `src_sel` = 1 and `mix_mask` = 0, the output is 0 whatever the channel samples are.
- R7: The output is floor(source · `vol_gain` / 2^23), saturated to 28 bits. `vol_gain` is a 26-bit two's-complement value with 23 fractional bits: 0x800000 is unity, 0x1000000 is 2.0, 0x3800000 is -1.0 and 0 is silence.
- R8: A source value or output outside [-2^27, 2^27-1] clamps to the nearest limit, for both positive and negative overflow.
- R9: `src_sel` and `mix_mask` are sampled at the edge that captures the input strobe. `vol_gain` is sampled one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Frame strobe; all six samples are valid |
| smp_lf | input | 28 | Left front sample, signed |
| smp_rf | input | 28 | Right front sample, signed |
| smp_ls | input | 28 | Left surround sample, signed |
| smp_rs | input | 28 | Right surround sample, signed |
| smp_c | input | 28 | Centre sample, signed |
| smp_sub | input | 28 | Subwoofer sample, signed |
| src_sel | input | 1 | 0 = bass-management sum, 1 = downmix mean |
| mix_mask | input | 5 | Main-channel enables for the downmix |
| vol_gain | input | 26 | Signed volume coefficient, 23 fractional bits |
| out_vld | output | 1 | Result strobe |
| out_smp | output | 28 | Subwoofer result, signed |

## Verification
The source selection, together with its mode and mask, is settled at the edge that captures `in_vld`. The volume product is settled one edge later, so each result is due on the second edge after its strobe. The reference model has a two-stage pipeline of its own. It samples the configuration on the same edges and is compared with the ports at every falling edge, in between rising edges. Directed cases change the volume between the two edges, and send single strobes that are checked one, two and three falling edges later. This confirms the latency and the hold of `out_smp` in between.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef logic signed [63:0] wide_t;

  // clamp a wide signed value into a w-bit two's-complement range
  function automatic wide_t sat_fit(input wide_t x, input int w);
    wide_t hi;
    wide_t lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (x > hi)      return hi;
    else if (x < lo) return lo;
    else             return x;
  endfunction

  // fixed-point multiply with floor rounding
  function automatic wide_t fx_mul(input wide_t a, input wide_t b, input int frac);
    return (a * b) >>> frac;
  endfunction

endpackage

// File: rtl/sbm_bass_path.sv
module sbm_bass_path
  import sbm_pkg::*;
#(
  parameter int     DW    = 28,
  parameter int     NMAIN = 5,
  parameter longint BOOST = 26527108,
  parameter int     FRAC  = 23,
  parameter int     SHIFT = 3
) (
  input  logic signed [DW-1:0] mains [NMAIN],
  input  logic signed [DW-1:0] sub_smp,
  output logic signed [DW-1:0] bass_smp
);

  wide_t boosted;
  wide_t total;

  always_comb begin
    boosted = fx_mul(64'(sub_smp), BOOST, FRAC);
    total   = boosted;
    for (int k = 0; k < NMAIN; k++) total = total + 64'(mains[k]);
    bass_smp = DW'(sat_fit(total >>> SHIFT, DW));
  end

endmodule

// File: rtl/sbm_downmix.sv
module sbm_downmix
  import sbm_pkg::*;
#(
  parameter int DW    = 28,
  parameter int NMAIN = 5
) (
  input  logic signed [DW-1:0]    mains [NMAIN],
  input  logic        [NMAIN-1:0] mask,
  output logic signed [DW-1:0]    mean_smp
);

  localparam int AW = DW + 3;

  logic signed [AW-1:0] pick [NMAIN];
  logic signed [AW-1:0] left_mix;
  logic signed [AW-1:0] right_mix;
  logic signed [AW-1:0] pair_sum;

  // masked channel taps
  generate
    for (genvar g = 0; g < NMAIN; g++) begin : g_pick
      assign pick[g] = mask[g] ? AW'(mains[g]) : '0;
    end
  endgenerate

  // index 0/2 left side, 1/3 right side, 4 centre shared at half weight
  assign left_mix  = pick[0] + pick[2] + (pick[4] >>> 1);
  assign right_mix = pick[1] + pick[3] + (pick[4] >>> 1);
  assign pair_sum  = left_mix + right_mix;
  assign mean_smp  = DW'(sat_fit(64'(pair_sum >>> 1), DW));

endmodule

// File: rtl/sbm_gain_stage.sv
module sbm_gain_stage
  import sbm_pkg::*;
#(
  parameter int DW   = 28,
  parameter int CW   = 26,
  parameter int FRAC = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_vld,
  input  logic signed [DW-1:0] s1_smp,
  input  logic signed [CW-1:0] gain,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_smp
);

  wide_t scaled;

  always_comb scaled = sat_fit(fx_mul(64'(s1_smp), 64'(gain), FRAC), DW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_smp <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) out_smp <= DW'(scaled);
    end
  end

  assert_stage_to_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_vld);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> (!out_vld && $stable(out_smp)));

  assert_zero_gain_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && gain == '0) |=> out_smp == '0);

endmodule

// File: rtl/sub_bass_mixer.sv
module sub_bass_mixer
  import sbm_pkg::*;
#(
  parameter int     DW    = 28,
  parameter int     CW    = 26,
  parameter int     FRAC  = 23,
  parameter longint BOOST = 26527108,
  parameter int     SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] smp_lf,
  input  logic signed [DW-1:0] smp_rf,
  input  logic signed [DW-1:0] smp_ls,
  input  logic signed [DW-1:0] smp_rs,
  input  logic signed [DW-1:0] smp_c,
  input  logic signed [DW-1:0] smp_sub,
  input  logic                 src_sel,
  input  logic [4:0]           mix_mask,
  input  logic signed [CW-1:0] vol_gain,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_smp
);

  localparam int NMAIN = 5;

  logic signed [DW-1:0] mains [NMAIN];
  logic signed [DW-1:0] bass_smp;
  logic signed [DW-1:0] mean_smp;
  logic                 s1_vld;
  logic signed [DW-1:0] s1_smp;

  assign mains[0] = smp_lf;
  assign mains[1] = smp_rf;
  assign mains[2] = smp_ls;
  assign mains[3] = smp_rs;
  assign mains[4] = smp_c;

  sbm_bass_path #(.DW(DW), .NMAIN(NMAIN), .BOOST(BOOST), .FRAC(FRAC), .SHIFT(SHIFT)) i_bass (
    .mains    (mains),
    .sub_smp  (smp_sub),
    .bass_smp (bass_smp)
  );

  sbm_downmix #(.DW(DW), .NMAIN(NMAIN)) i_dmx (
    .mains    (mains),
    .mask     (mix_mask),
    .mean_smp (mean_smp)
  );

  // stage 1: source choice, mode and mask taken here
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_smp <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) s1_smp <= src_sel ? mean_smp : bass_smp;
    end
  end

  // stage 2: volume, taken one edge later
  sbm_gain_stage #(.DW(DW), .CW(CW), .FRAC(FRAC)) i_gain (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_vld  (s1_vld),
    .s1_smp  (s1_smp),
    .gain    (vol_gain),
    .out_vld (out_vld),
    .out_smp (out_smp)
  );

  assert_strobe_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> s1_vld);

  assert_empty_mask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && src_sel && mix_mask == '0) |=> s1_smp == '0);

  assert_quiet_bass_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !src_sel && smp_sub == '0 && smp_lf == '0 && smp_rf == '0 &&
     smp_ls == '0 && smp_rs == '0 && smp_c == '0) |=> s1_smp == '0);

endmodule

// File: tb/test_sub_bass_mixer.sv
module test_sub_bass_mixer;

  localparam int     PERIOD = 10;
  localparam longint K10DB  = 26527108;
  localparam longint MAXV   = 134217727;
  localparam longint MINV   = -134217728;
  localparam longint UNITY  = 8388608;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic signed [27:0] smp_lf = '0, smp_rf = '0, smp_ls = '0, smp_rs = '0, smp_c = '0, smp_sub = '0;
  logic src_sel = 1'b0;
  logic [4:0] mix_mask = '0;
  logic signed [25:0] vol_gain = 26'sd8388608;
  logic out_vld;
  logic signed [27:0] out_smp;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  sub_bass_mixer i_sub_bass_mixer (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .smp_lf(smp_lf), .smp_rf(smp_rf), .smp_ls(smp_ls), .smp_rs(smp_rs),
    .smp_c(smp_c), .smp_sub(smp_sub), .src_sel(src_sel), .mix_mask(mix_mask),
    .vol_gain(vol_gain), .out_vld(out_vld), .out_smp(out_smp)
  );

  function automatic longint clampv(longint v);
    return (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
  endfunction

  function automatic longint ref_source(bit mode, bit [4:0] m, longint lf, longint rf,
                                        longint ls, longint rs, longint c, longint sb);
    longint l, r;
    if (!mode) return clampv(((sb * K10DB) >>> 23) + lf + rf + ls + rs + c >>> 3);
    l = (m[0] ? lf : 0) + (m[2] ? ls : 0) + (m[4] ? (c >>> 1) : 0);
    r = (m[1] ? rf : 0) + (m[3] ? rs : 0) + (m[4] ? (c >>> 1) : 0);
    return clampv((l + r) >>> 1);
  endfunction

  function automatic longint ref_volume(longint s, longint g);
    return clampv((s * g) >>> 23);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural two-stage reference, compared on every falling edge
  bit     m1_v = 0, m2_v = 0, m1_mode = 0, m2_mode = 0;
  longint m1_s = 0, m2_s = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1_v <= 0; m2_v <= 0; m1_s <= 0; m2_s <= 0;
    end else begin
      m1_v <= in_vld;
      if (in_vld) begin
        m1_s    <= ref_source(src_sel, mix_mask, smp_lf, smp_rf, smp_ls, smp_rs, smp_c, smp_sub);
        m1_mode <= src_sel;
      end
      m2_v <= m1_v;
      if (m1_v) begin
        m2_s    <= ref_volume(m1_s, longint'(vol_gain));
        m2_mode <= m1_mode;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R1 vld in reset", longint'(out_vld), 0);
      check("R1 data in reset", longint'(out_smp), 0);
    end else begin
      check("R2 strobe timing", longint'(out_vld), longint'(m2_v));
      check(m2_mode ? "R4 model data" : "R3 model data", longint'(out_smp), m2_s);
    end
  end

  // one strobe; optionally a new volume between the two edges
  task automatic send(bit mode, bit [4:0] m, longint lf, longint rf, longint ls, longint rs,
                      longint c, longint sb, longint g, bit late, longint g2,
                      string tag, longint exp);
    @(negedge clk);
    src_sel = mode; mix_mask = m; vol_gain = 26'(g);
    smp_lf = 28'(lf); smp_rf = 28'(rf); smp_ls = 28'(ls);
    smp_rs = 28'(rs); smp_c = 28'(c); smp_sub = 28'(sb);
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check("R2 not yet valid", longint'(out_vld), 0);
    if (late) vol_gain = 26'(g2);
    @(negedge clk);
    check("R2 valid after two edges", longint'(out_vld), 1);
    check(tag, longint'(out_smp), exp);
    @(negedge clk);
    check("R2 single pulse", longint'(out_vld), 0);
    check("R2 held data", longint'(out_smp), exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R3 boost and main sum
    send(0, 5'h00, 0, 0, 0, 0, 0, 8388608, UNITY, 0, 0, "R3 boosted sub", 3315888);
    send(0, 5'h00, 800, 800, 800, 800, 800, 0, UNITY, 0, 0, "R3 main sum", 500);
    // R4 full downmix; R5 sub excluded
    send(1, 5'h1F, 1000, 2000, 300, 400, 600, 99999, UNITY, 0, 0, "R4 full mask", 2150);
    send(1, 5'h01, 1000, 2000, 300, 400, 600, -5000, UNITY, 0, 0, "R5 left front only", 500);
    send(1, 5'h10, 1000, 2000, 300, 400, 600, 7, UNITY, 0, 0, "R5 centre only", 300);
    send(1, 5'h0A, 1000, 2000, 300, 400, 600, 0, UNITY, 0, 0, "R5 right pair", 1200);
    // R6 empty mask
    send(1, 5'h00, 1000, 2000, 300, 400, 600, 12345, UNITY, 0, 0, "R6 empty mask", 0);
    // R7 volume values
    send(1, 5'h1F, 1000, 2000, 300, 400, 600, 0, 16777216, 0, 0, "R7 gain two", 4300);
    send(1, 5'h1F, 1000, 2000, 300, 400, 600, 0, -8388608, 0, 0, "R7 gain minus one", -2150);
    send(1, 5'h1F, 1000, 2000, 300, 400, 600, 0, 0, 0, 0, "R7 gain zero", 0);
    // R8 saturation
    send(0, 5'h00, MAXV, MAXV, MAXV, MAXV, MAXV, MAXV, UNITY, 0, 0, "R8 bass clamp high", MAXV);
    send(0, 5'h00, MINV, MINV, MINV, MINV, MINV, MINV, UNITY, 0, 0, "R8 bass clamp low", MINV);
    send(1, 5'h1F, MAXV, 0, MAXV, 0, 0, 0, UNITY, 0, 0, "R8 downmix clamp", MAXV);
    send(1, 5'h1F, 40000000, 40000000, 0, 0, 0, 0, 33554431, 0, 0, "R8 volume clamp", MAXV);
    // R9 volume taken at the second edge
    send(1, 5'h1F, 1000, 2000, 300, 400, 600, 0, UNITY, 1, 16777216, "R9 late volume", 4300);
    // random back-to-back traffic checked by the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      in_vld   = ($urandom % 4) != 0;
      src_sel  = $urandom % 2;
      mix_mask = 5'($urandom);
      vol_gain = 26'($urandom);
      smp_lf = 28'($urandom); smp_rf = 28'($urandom); smp_ls = 28'($urandom);
      smp_rs = 28'($urandom); smp_c = 28'($urandom); smp_sub = 28'($urandom);
    end
    @(negedge clk);
    in_vld = 1'b0;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule